// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block is the control path a processor core uses to decide, at each instruction boundary, whether an interrupt must be serviced, and then to carry out the entry into the service routine. It weighs an internal exception, a latched non-maskable request, a maskable request level and the single-step trap flag in a fixed order. For a maskable request it runs a two-cycle acknowledge handshake to collect the type byte. It then saves the flags, code segment and instruction pointer on the stack and fetches the handler address from the vector table in segment zero.

The core signals the end of each instruction with `instr_done` and gives the following IP on `next_ip`. Flag changes made by ordinary instructions come in through `flags_we`. Stack writes leave on the push port, one 16-bit word per cycle. Vector-table words come back on `rd_data` in the same cycle as `rd_addr`. A halt instruction parks the block until an external request arrives.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, CS reads FFFFh and IP, FLAGS and SP read 0000h. `halted`, `done`, `push_en` and `inta` are all low.
- R2: Exception and maskable requests have no effect unless `instr_done` is high in the running state: no push, no acknowledge and no IP change.
- R3: At a boundary the winner is chosen in this order: an exception with type `exc_type`, then a pending NMI, then INTR only when IF (FLAGS bit 9) is 1, then single-step when TF (FLAGS bit 8) is 1.
- R4: A rising edge on `nmi` is held pending until it is serviced. It uses type 2, and a pending NMI not served at one boundary is served at a later one.
- R5: An INTR entry raises `inta` for exactly two consecutive cycles, and the type is the `ack_vec` byte present in the second of them.
- R6: An entry pushes FLAGS, then CS, then IP, one per cycle. Each push goes to SP minus 2, and SP then holds that decremented value.
- R7: The pushed FLAGS word is the value before entry. Bits 9 and 8 are cleared right after that push, and all other bits are kept.
- R8: The handler IP is the word read at type×4 and the handler CS is the word read at type×4+2.
- R9: If TF was 1 when an entry other than single-step began, a second entry of type 1 follows at once and pushes the first handler's CS:IP.
- R10: A boundary with `halt_req` and no winner sets `halted`. While halted, `instr_done` and exceptions are ignored, and only an NMI edge or INTR with IF=1 starts an entry.
- R11: `done` is high for one cycle, in the first cycle in which the final handler CS:IP is visible on `cs_o`/`ip_o`.
- R12: A boundary with no winner loads IP from `next_ip` and pushes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_done | input | 1 | Current instruction has finished |
| next_ip | input | 16 | IP of the following instruction |
| halt_req | input | 1 | Finished instruction was a halt |
| exc_req | input | 1 | Internal exception request |
| exc_type | input | 8 | Type of the internal exception |
| nmi | input | 1 | Non-maskable request, edge sensitive |
| intr | input | 1 | Maskable request, level sensitive |
| flags_we | input | 1 | Write FLAGS from the core |
| flags_wr_data | input | 16 | New FLAGS value |
| ack_vec | input | 8 | Type byte returned during acknowledge |
| rd_data | input | 16 | Vector-table word for `rd_addr` |
| inta | output | 1 | Acknowledge handshake active |
| rd_en | output | 1 | Vector-table read |
| rd_addr | output | 16 | Vector-table byte offset in segment 0 |
| push_en | output | 1 | Stack push request |
| push_addr | output | 16 | Stack offset of the push |
| push_data | output | 16 | Word being pushed |
| flags_o | output | 16 | Current FLAGS |
| cs_o | output | 16 | Current CS |
| ip_o | output | 16 | Current IP |
| sp_o | output | 16 | Current SP |
| halted | output | 1 | Halt state |
| done | output | 1 | Entry finished pulse |

## Verification
The assertions assume `flags_we` is raised only while the block is running or halted, never in the middle of an entry. They also assume that `instr_done` means something only in the running state and that NMI pulses are at least one clock long. The bench writes flags only between entries, and it waits for `done` before it issues the next boundary. Its NMI pulses last two cycles and end before the boundary that is meant to see them. `ack_vec` carries a wrong byte in every cycle except the second acknowledge cycle, so sampling in the wrong cycle shows up as a wrong handler address.

// File: rtl/irq_entry_pkg.sv
`timescale 1ns/1ps
package irq_entry_pkg;
  localparam int IF_POS   = 9;
  localparam int TF_POS   = 8;
  localparam int NMI_VEC  = 2;
  localparam int STEP_VEC = 1;

  typedef enum logic [1:0] {
    SRC_EXC,
    SRC_NMI,
    SRC_INTR,
    SRC_STEP
  } src_e;

  typedef enum logic [3:0] {
    ST_RUN,
    ST_HALT,
    ST_ACK1,
    ST_ACK2,
    ST_PUSHF,
    ST_PUSHCS,
    ST_PUSHIP,
    ST_LDIP,
    ST_LDCS
  } st_e;
endpackage

// File: rtl/irq_nmi_latch.sv
`timescale 1ns/1ps
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi,
  input  logic clr,
  output logic pend
);
  logic nmi_d;
  logic rise;
  logic pend_n;

  always_comb begin
    rise   = nmi & ~nmi_d;
    pend_n = (pend & ~clr) | rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_d <= 1'b0;
      pend  <= 1'b0;
    end else begin
      nmi_d <= nmi;
      pend  <= pend_n;
    end
  end

  // R4: an edge is never lost
  p_nmi_catch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi) |=> pend);
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick
  import irq_entry_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             exc_req,
  input  logic [VEC_W-1:0] exc_type,
  input  logic             nmi_pend,
  input  logic             intr_ok,
  input  logic             step_ok,
  output logic             take,
  output src_e             src,
  output logic [VEC_W-1:0] vec
);
  always_comb begin
    take = 1'b1;
    src  = SRC_EXC;
    vec  = exc_type;
    if (exc_req) begin
      src = SRC_EXC;
      vec = exc_type;
    end else if (nmi_pend) begin
      src = SRC_NMI;
      vec = VEC_W'(NMI_VEC);
    end else if (intr_ok) begin
      src = SRC_INTR;
      vec = '0;
    end else if (step_ok) begin
      src = SRC_STEP;
      vec = VEC_W'(STEP_VEC);
    end else begin
      take = 1'b0;
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
`timescale 1ns/1ps
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int          WORD_W = 16,
  parameter int          VEC_W  = 8,
  parameter logic [15:0] CS_RST = 16'hFFFF,
  parameter logic [15:0] SP_RST = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_done,
  input  logic [WORD_W-1:0] next_ip,
  input  logic              halt_req,
  input  logic              exc_req,
  input  logic [VEC_W-1:0]  exc_type,
  input  logic              nmi,
  input  logic              intr,
  input  logic              flags_we,
  input  logic [WORD_W-1:0] flags_wr_data,
  input  logic [VEC_W-1:0]  ack_vec,
  input  logic [WORD_W-1:0] rd_data,
  output logic              inta,
  output logic              rd_en,
  output logic [WORD_W-1:0] rd_addr,
  output logic              push_en,
  output logic [WORD_W-1:0] push_addr,
  output logic [WORD_W-1:0] push_data,
  output logic [WORD_W-1:0] flags_o,
  output logic [WORD_W-1:0] cs_o,
  output logic [WORD_W-1:0] ip_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              halted,
  output logic              done
);
  localparam int PAD_W = WORD_W - VEC_W - 2;
  localparam logic [WORD_W-1:0] WSTEP = WORD_W'(2);

  // reset: asserted at once, released on a clock edge
  logic rs_a, rs_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_a <= 1'b0;
      rs_b <= 1'b0;
    end else begin
      rs_a <= 1'b1;
      rs_b <= rs_a;
    end
  end
  logic rst_s;
  assign rst_s = rs_b;

  st_e               st, st_n;
  src_e              src_q, src_n;
  logic [VEC_W-1:0]  vec_q, vec_n;
  logic [WORD_W-1:0] cs_q, cs_n, ip_q, ip_n, sp_q, sp_n, flags_q, flags_n;
  logic [WORD_W-1:0] ipnew_q, ipnew_n;
  logic              temp_q, temp_n, done_q, done_n;

  logic at_bound, in_halt, nmi_pend, nmi_clr, take;
  src_e pk_src;
  logic [VEC_W-1:0] pk_vec;

  assign at_bound = (st == ST_RUN) && instr_done;
  assign in_halt  = (st == ST_HALT);

  irq_pick #(.VEC_W(VEC_W)) u_pick (
    .exc_req  (exc_req & at_bound),
    .exc_type (exc_type),
    .nmi_pend (nmi_pend & (at_bound | in_halt)),
    .intr_ok  (intr & flags_q[IF_POS] & (at_bound | in_halt)),
    .step_ok  (flags_q[TF_POS] & at_bound),
    .take     (take),
    .src      (pk_src),
    .vec      (pk_vec)
  );

  assign nmi_clr = take && (pk_src == SRC_NMI);

  irq_nmi_latch u_nmi (
    .clk   (clk),
    .rst_n (rst_s),
    .nmi   (nmi),
    .clr   (nmi_clr),
    .pend  (nmi_pend)
  );

  // datapath outputs
  logic [WORD_W-1:0] tbl_base;
  assign tbl_base  = {{PAD_W{1'b0}}, vec_q, 2'b00};
  assign push_en   = (st == ST_PUSHF) || (st == ST_PUSHCS) || (st == ST_PUSHIP);
  assign push_addr = sp_q - WSTEP;
  assign rd_en     = (st == ST_LDIP) || (st == ST_LDCS);
  assign rd_addr   = tbl_base + ((st == ST_LDCS) ? WSTEP : '0);
  assign inta      = (st == ST_ACK1) || (st == ST_ACK2);

  always_comb begin
    case (st)
      ST_PUSHF:  push_data = flags_q;
      ST_PUSHCS: push_data = cs_q;
      default:   push_data = ip_q;
    endcase
  end

  // next-state process
  always_comb begin
    st_n    = st;
    src_n   = src_q;
    vec_n   = vec_q;
    cs_n    = cs_q;
    ip_n    = ip_q;
    sp_n    = sp_q;
    flags_n = flags_q;
    temp_n  = temp_q;
    ipnew_n = ipnew_q;
    done_n  = 1'b0;
    if (push_en) sp_n = sp_q - WSTEP;
    case (st)
      ST_RUN, ST_HALT: begin
        if (flags_we) flags_n = flags_wr_data;
        if (at_bound) ip_n = next_ip;
        if (take) begin
          src_n = pk_src;
          vec_n = pk_vec;
          st_n  = (pk_src == SRC_INTR) ? ST_ACK1 : ST_PUSHF;
        end else if (at_bound && halt_req) begin
          st_n = ST_HALT;
        end
      end
      ST_ACK1: st_n = ST_ACK2;
      ST_ACK2: begin
        vec_n = ack_vec;
        st_n  = ST_PUSHF;
      end
      ST_PUSHF: begin
        temp_n          = flags_q[TF_POS];
        flags_n[IF_POS] = 1'b0;
        flags_n[TF_POS] = 1'b0;
        st_n            = ST_PUSHCS;
      end
      ST_PUSHCS: st_n = ST_PUSHIP;
      ST_PUSHIP: st_n = ST_LDIP;
      ST_LDIP: begin
        ipnew_n = rd_data;
        st_n    = ST_LDCS;
      end
      ST_LDCS: begin
        cs_n = rd_data;
        ip_n = ipnew_q;
        if (temp_q && (src_q != SRC_STEP)) begin
          src_n = SRC_STEP;
          vec_n = VEC_W'(STEP_VEC);
          st_n  = ST_PUSHF;
        end else begin
          done_n = 1'b1;
          st_n   = ST_RUN;
        end
      end
      default: st_n = ST_RUN;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st      <= ST_RUN;
      src_q   <= SRC_EXC;
      vec_q   <= '0;
      cs_q    <= WORD_W'(CS_RST);
      ip_q    <= '0;
      sp_q    <= WORD_W'(SP_RST);
      flags_q <= '0;
      temp_q  <= 1'b0;
      ipnew_q <= '0;
      done_q  <= 1'b0;
    end else begin
      st      <= st_n;
      src_q   <= src_n;
      vec_q   <= vec_n;
      cs_q    <= cs_n;
      ip_q    <= ip_n;
      sp_q    <= sp_n;
      flags_q <= flags_n;
      temp_q  <= temp_n;
      ipnew_q <= ipnew_n;
      done_q  <= done_n;
    end
  end

  assign flags_o = flags_q;
  assign cs_o    = cs_q;
  assign ip_o    = ip_q;
  assign sp_o    = sp_q;
  assign halted  = in_halt;
  assign done    = done_q;

  // R6: every push moves SP down by one word
  p_sp_dec_r6: assert property (@(posedge clk) disable iff (!rst_s)
    push_en |=> sp_o == $past(sp_o) - WSTEP);
  // R5: acknowledge is exactly two cycles long
  p_ack_rise_r5: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(inta) |=> inta);
  p_ack_end_r5: assert property (@(posedge clk) disable iff (!rst_s)
    (inta && $past(inta)) |=> !inta);
  // R7: mask and trap bits are clear once FLAGS is on the stack
  p_if_tf_clr_r7: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_PUSHCS) |-> (!flags_q[IF_POS] && !flags_q[TF_POS]));
  // R3: an exception at a boundary wins with its own type
  p_exc_first_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_RUN && instr_done && exc_req) |=>
      (st == ST_PUSHF && vec_q == $past(exc_type)));
  // R8: the segment word follows the offset word
  p_tbl_pair_r8: assert property (@(posedge clk) disable iff (!rst_s)
    (st == ST_LDCS) |-> (rd_en && rd_addr == $past(rd_addr) + WSTEP));
  // R10: halt holds with no external request
  p_halt_stay_r10: assert property (@(posedge clk) disable iff (!rst_s)
    (in_halt && !nmi_pend && !(intr && flags_q[IF_POS]) && !flags_we) |=> halted);
  // R11: single pulse, back in the running state
  p_done_once_r11: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> (st == ST_RUN && !$past(done)));
endmodule

// File: tb/irq_entry_seq_tb.sv
`timescale 1ns/1ps
module irq_entry_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic instr_done = 0, halt_req = 0, exc_req = 0, nmi = 0, intr = 0, flags_we = 0;
  logic [15:0] next_ip = 0, flags_wr_data = 0;
  logic [7:0]  exc_type = 0, ack_vec = 0, ack_good = 0;
  logic [15:0] rd_data;
  logic inta, rd_en, push_en, halted, done;
  logic [15:0] rd_addr, push_addr, push_data, flags_o, cs_o, ip_o, sp_o;

  int nchk = 0, nfail = 0, pc = 0, ic = 0;
  logic [15:0] pa [0:7];
  logic [15:0] pd [0:7];
  logic [15:0] m_flags = 0, m_cs = 16'hFFFF, m_ip = 0, m_sp = 0;
  bit m_np = 0;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] tbl(input logic [15:0] a);
    return (a * 16'd37) ^ 16'hC3A5;
  endfunction
  assign rd_data = tbl(rd_addr);

  irq_entry_seq u_dut (
    .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .next_ip(next_ip),
    .halt_req(halt_req), .exc_req(exc_req), .exc_type(exc_type), .nmi(nmi),
    .intr(intr), .flags_we(flags_we), .flags_wr_data(flags_wr_data),
    .ack_vec(ack_vec), .rd_data(rd_data), .inta(inta), .rd_en(rd_en),
    .rd_addr(rd_addr), .push_en(push_en), .push_addr(push_addr),
    .push_data(push_data), .flags_o(flags_o), .cs_o(cs_o), .ip_o(ip_o),
    .sp_o(sp_o), .halted(halted), .done(done)
  );

  // observe pushes and acknowledge cycles; wrong byte outside 2nd ack cycle
  always @(negedge clk) begin
    if (push_en) begin
      if (pc < 8) begin
        pa[pc] = push_addr;
        pd[pc] = push_data;
      end
      pc++;
    end
    if (inta) begin
      ic++;
      ack_vec = (ic == 2) ? ack_good : ~ack_good;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  task automatic setflags(input logic [15:0] v);
    @(negedge clk);
    flags_we = 1; flags_wr_data = v;
    @(negedge clk);
    flags_we = 0;
    m_flags = v;
  endtask

  task automatic nmi_pulse();
    @(negedge clk); nmi = 1;
    @(negedge clk);
    @(negedge clk); nmi = 0;
    m_np = 1;
  endtask

  task automatic expect_entry(input logic [7:0] v, input bit step, input string tag);
    bit ch;
    int n;
    logic [7:0] vv;
    ch = m_flags[8] && !step;
    n  = ch ? 6 : 3;
    vv = v;
    for (int k = 0; k < 80; k++) begin
      if (done) break;
      @(negedge clk);
    end
    chk(done == 1'b1, {tag, " R11 done seen"}, done, 1);
    chk(pc == n, {tag, " R6 push count"}, pc, n);
    for (int e = 0; e < 2; e++) begin
      if (e == 0 || ch) begin
        chk(pa[e*3] == m_sp - 16'd2, {tag, " R6 flags addr"}, pa[e*3], m_sp - 16'd2);
        chk(pd[e*3] == m_flags, {tag, " R7 flags data"}, pd[e*3], m_flags);
        chk(pa[e*3+1] == m_sp - 16'd4 && pd[e*3+1] == m_cs, {tag, " R6 cs push"}, pd[e*3+1], m_cs);
        chk(pa[e*3+2] == m_sp - 16'd6 && pd[e*3+2] == m_ip, {tag, " R6 ip push"}, pd[e*3+2], m_ip);
        m_sp    = m_sp - 16'd6;
        m_flags = m_flags & 16'hFCFF;
        m_ip    = tbl({6'b0, vv, 2'b00});
        m_cs    = tbl({6'b0, vv, 2'b00} + 16'd2);
        vv      = 8'd1;
      end
    end
    if (ch) chk(1'b1, {tag, " R9 chained step"}, 0, 0);
    chk(cs_o == m_cs, {tag, " R8 cs"}, cs_o, m_cs);
    chk(ip_o == m_ip, {tag, " R8 ip"}, ip_o, m_ip);
    chk(sp_o == m_sp, {tag, " R6 sp"}, sp_o, m_sp);
    chk(flags_o == m_flags, {tag, " R7 flags"}, flags_o, m_flags);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R11 one cycle"}, done, 0);
  endtask

  task automatic boundary(input bit exc, input logic [7:0] et, input bit it,
                          input logic [15:0] nip, input bit hreq, input logic [7:0] av);
    @(negedge clk);
    pc = 0; ic = 0; ack_good = av;
    exc_req = exc; exc_type = et; intr = it; instr_done = 1; next_ip = nip; halt_req = hreq;
    @(negedge clk);
    instr_done = 0; exc_req = 0; intr = 0; halt_req = 0;
    m_ip = nip;
    if (exc) expect_entry(et, 0, "R3 exception");
    else if (m_np) begin
      m_np = 0;
      expect_entry(8'd2, 0, "R4 nmi");
    end else if (it && m_flags[9]) begin
      expect_entry(av, 0, "R5 intr");
      chk(ic == 2, "R5 ack cycles", ic, 2);
    end else if (m_flags[8]) expect_entry(8'd1, 1, "R9 step");
    else begin
      chk(ip_o == nip, "R12 ip load", ip_o, nip);
      chk(pc == 0, "R12 no push", pc, 0);
      chk(halted == hreq, "R10 halt state", halted, hreq);
    end
  endtask

  task automatic wake_nmi();
    @(negedge clk);
    pc = 0; nmi = 1;
    expect_entry(8'd2, 0, "R10 nmi wake");
    nmi = 0;
    chk(!halted, "R10 left halt", halted, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cs_o == 16'hFFFF, "R1 cs", cs_o, 16'hFFFF);
    chk(ip_o == 0 && sp_o == 0, "R1 ip/sp", {ip_o, sp_o}, 0);
    chk(flags_o == 0, "R1 flags", flags_o, 0);
    chk(!halted && !done && !push_en && !inta, "R1 outputs", {halted, done, push_en, inta}, 0);

    // R2 requests away from a boundary do nothing
    setflags(16'h0200);
    @(negedge clk);
    pc = 0; ic = 0; exc_req = 1; intr = 1;
    repeat (4) @(negedge clk);
    exc_req = 0; intr = 0;
    @(negedge clk);
    chk(pc == 0 && ic == 0, "R2 no push or ack", {pc, ic}, 0);
    chk(ip_o == m_ip, "R2 ip kept", ip_o, m_ip);

    boundary(0, 0, 0, 16'h0100, 0, 0);          // R12
    setflags(16'h0000);
    boundary(0, 0, 1, 16'h0102, 0, 8'h11);      // R3 INTR masked
    setflags(16'h0200);
    boundary(0, 0, 1, 16'h0104, 0, 8'h36);      // R5 INTR taken
    setflags(16'h0200);
    nmi_pulse();
    boundary(1, 8'h00, 1, 16'h0106, 0, 8'h22);  // R3 exception beats NMI and INTR
    boundary(0, 0, 0, 16'h0108, 0, 0);          // R4 NMI still pending
    setflags(16'h0300);
    boundary(1, 8'h05, 0, 16'h010A, 0, 0);      // R9 chain
    setflags(16'h0100);
    boundary(0, 0, 0, 16'h010C, 0, 0);          // R3 step alone, no chain
    setflags(16'h0000);
    boundary(0, 0, 0, 16'h0110, 1, 0);          // R10 halt
    @(negedge clk); instr_done = 1; next_ip = 16'hBEEF; exc_req = 1; pc = 0;
    @(negedge clk); instr_done = 0; exc_req = 0;
    @(negedge clk);
    chk(ip_o == m_ip && halted && pc == 0, "R10 boundary ignored", ip_o, m_ip);
    @(negedge clk); intr = 1;
    repeat (3) @(negedge clk);
    chk(halted && pc == 0, "R10 masked intr ignored", halted, 1);
    intr = 0;
    wake_nmi();
    boundary(0, 0, 0, 16'h0120, 1, 0);
    setflags(16'h0200);
    @(negedge clk);
    pc = 0; ic = 0; ack_good = 8'h4C; intr = 1;
    expect_entry(8'h4C, 0, "R10 intr wake");
    intr = 0;

    // constrained random boundaries
    for (int it = 0; it < 60; it++) begin
      logic [15:0] f;
      bit ex, ir, hq;
      f = ($urandom() & 16'hFCFF) | (($urandom() % 2) != 0 ? 16'h0200 : 16'h0)
          | (($urandom() % 4) == 0 ? 16'h0100 : 16'h0);
      setflags(f);
      if (($urandom() % 4) == 0) nmi_pulse();
      ex = ($urandom() % 4) == 0;
      ir = ($urandom() % 2) == 0;
      hq = ($urandom() % 6) == 0;
      boundary(ex, 8'($urandom()), ir, 16'($urandom()), hq, 8'($urandom()));
      if (halted) wake_nmi();
    end
    summary();
  end
endmodule